// File: doc/BRIEF.md
# RTD Conversion Sequencer with Threshold Fault Latching

This block controls when resistance-ratio conversions happen and what is kept from them. In continuous mode it runs one conversion after another. In normally-off mode it runs a single conversion only when software requests one. The request is armed by a configuration write and fires on the chip-select rising edge that closes the serial transaction. Conversion time is counted in ticks of a prescaled enable. The first conversion after an idle period takes the long single-shot time. Conversions chained in continuous mode take the shorter continuous time. The filter selection picks between two pairs of these durations.

When the timer expires, the block offers `adc_ready` to an abstract converter model. That model delivers a 15-bit ratio code with a valid/ready handshake. Back-pressure runs one way only: the block is the sole source of readiness. The converter holds `adc_valid` and `adc_code` until the cycle in which both `adc_valid` and `adc_ready` are high. `adc_ready` is never raised before the conversion time has elapsed.

Each accepted code is compared against programmable high and low limits. Fault flags are latched into an 8-bit status word. An active-low data-ready output announces every stored result. While the input-protection flag is active, codes are dropped and the stored result stays frozen.

Top module: `rtd_conv_ctrl`

## Requirements
- R1: After reset, `result`, `fault_status` and `cfg_q` read 0, `drdy_n` reads 1 and `adc_ready` reads 0. The high limit resets to FFFFh and the low limit resets to 0000h.
- R2: With `cfg_q[6]`=1 (continuous), conversions repeat without a gap. A conversion started from idle lasts T_SGL ticks for the selected filter. Each conversion chained directly after an accepted code lasts T_CONT ticks. `adc_ready` rises T+1 cycles after the enabling write and T cycles after an acceptance.
- R3: In normally-off mode no conversion runs unless requested. Writing 1 to bit 5 while writing 0 to bit 6 sets `cfg_q[5]`. The next `cs_rise` clears `cfg_q[5]` and starts one T_SGL conversion.
- R4: A configuration write that sets bit 5 together with bit 3 or bit 2 leaves both `cfg_q[5]` and `cfg_q[3:2]` unchanged. A later `cs_rise` starts nothing.
- R5: The filter bit (`cfg_q[0]`: 1 selects T_SGL50/T_CONT50, 0 selects T_SGL60/T_CONT60) is taken when a conversion starts. Changing it mid-conversion does not alter that conversion's length.
- R6: `result[15:1]` holds the last stored code. `result[0]` is 1 exactly when any `fault_status` bit is set.
- R7: A stored code greater than or equal to the high limit bits [15:1] sets `fault_status[7]`. The flag stays set until cleared.
- R8: A stored code less than or equal to the low limit bits [15:1] sets `fault_status[6]`. The flag stays set until cleared.
- R9: While `ovuv_fault` is 1, `fault_status[2]` sets the next cycle. Any code accepted during that time is discarded, with `result` and `drdy_n` unchanged. Storing resumes once the flag drops.
- R10: A configuration write with bit 1 = 1 and bits 5, 3 and 2 all 0 clears `fault_status[7:2]`. Any other write clears nothing. `cfg_q[1]` always reads 0. Bit 2 sets again at once if `ovuv_fault` is still 1.
- R11: `drdy_n` goes low the cycle after a code is stored and returns high after a `rd_result` pulse. A store in the same cycle as a read wins.
- R12: `adc_ready` stays high, and `result` stays unchanged, until a code is accepted. `adc_ready` falls the cycle after acceptance.
- R13: Bits 3:2 of a configuration write that is not ignored under R4 are held in `cfg_q[3:2]` for the fault-cycle sequencer. A `fcyc_done` pulse returns them to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled enable that advances the conversion timer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte (7 bias, 6 continuous, 5 one-shot, 4 three-wire, 3:2 fault cycle, 1 clear, 0 filter 50 Hz) |
| thr_we | input | 1 | Limit write strobe |
| thr_sel | input | 1 | Selects the limit to write: 1 high, 0 low |
| thr_wdata | input | 16 | Limit value, bits [15:1] compared, bit 0 ignored |
| cs_rise | input | 1 | One-cycle pulse at the end of a serial transaction |
| fcyc_done | input | 1 | Fault-cycle sequencer finished; clears `cfg_q[3:2]` |
| rd_result | input | 1 | Pulse when the result registers are read |
| ovuv_fault | input | 1 | Input-protection over/undervoltage flag |
| adc_valid | input | 1 | Converter model offers a code |
| adc_code | input | 15 | Ratio code from the converter model |
| adc_ready | output | 1 | Block accepts a code this cycle |
| cfg_q | output | 8 | Configuration readback |
| result | output | 16 | Stored code in [15:1], summary fault in [0] |
| fault_status | output | 8 | Latched fault flags (7 high, 6 low, 2 voltage) |
| drdy_n | output | 1 | Active-low data ready |

## Verification
The assertions assume the converter model raises `adc_valid` only in answer to `adc_ready`. They also assume it holds its code until accepted. The stimulus meets this by driving one-cycle valid pulses and only after it has seen `adc_ready` high. The one-shot assertion is conditioned on `cs_rise` not landing in a configuration-write cycle. The bench never issues the two together, and it keeps `tick` high so that durations map directly to cycles. Limit and mode writes are placed while a conversion is running and never in an acceptance cycle. A full sweep of codes around both limits is thus compared against arithmetic expectations.

// File: rtl/rtd_ctrl_pkg.sv
package rtd_ctrl_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_t;

  // configuration bit positions (decoded by the serial-side register file)
  localparam int CB_BIAS    = 7;
  localparam int CB_AUTO    = 6;
  localparam int CB_ONESHOT = 5;
  localparam int CB_3WIRE   = 4;
  localparam int CB_FCYC_HI = 3;
  localparam int CB_FCYC_LO = 2;
  localparam int CB_CLEAR   = 1;
  localparam int CB_FILT50  = 0;

  // status bit positions
  localparam int SB_HIGH = 7;
  localparam int SB_LOW  = 6;
  localparam int SB_VOLT = 2;

  localparam logic [7:0] STATUS_CLR_MASK = 8'hFC;

endpackage

// File: rtl/rtd_cfg_reg.sv
module rtd_cfg_reg
  import rtd_ctrl_pkg::*;
#(
  parameter int CODE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              thr_we,
  input  logic              thr_sel,
  input  logic [CODE_W:0]   thr_wdata,
  input  logic              cs_rise,
  input  logic              fcyc_done,
  output logic [7:0]        cfg_q,
  output logic              auto_en,
  output logic              filt50,
  output logic              os_fire,
  output logic              clr_pulse,
  output logic [CODE_W-1:0] hi_lim,
  output logic [CODE_W-1:0] lo_lim
);
  localparam int RES_W = CODE_W + 1;

  logic             bias_q, auto_q, os_q, wire3_q, filt_q;
  logic [1:0]       fcyc_q;
  logic [RES_W-1:0] hi_q, lo_q;
  logic             combo;

  // one-shot together with a fault-cycle request: both dropped
  assign combo = cfg_wdata[CB_ONESHOT] &
                 (cfg_wdata[CB_FCYC_HI] | cfg_wdata[CB_FCYC_LO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_q  <= 1'b0;
      auto_q  <= 1'b0;
      os_q    <= 1'b0;
      wire3_q <= 1'b0;
      filt_q  <= 1'b0;
      fcyc_q  <= 2'b00;
    end else begin
      if (cs_rise)   os_q   <= 1'b0;
      if (fcyc_done) fcyc_q <= 2'b00;
      if (cfg_we) begin
        bias_q  <= cfg_wdata[CB_BIAS];
        auto_q  <= cfg_wdata[CB_AUTO];
        wire3_q <= cfg_wdata[CB_3WIRE];
        filt_q  <= cfg_wdata[CB_FILT50];
        if (!combo) begin
          os_q   <= cfg_wdata[CB_ONESHOT] & ~cfg_wdata[CB_AUTO];
          fcyc_q <= cfg_wdata[CB_FCYC_HI:CB_FCYC_LO];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '1;
      lo_q <= '0;
    end else if (thr_we) begin
      if (thr_sel) hi_q <= thr_wdata;
      else         lo_q <= thr_wdata;
    end
  end

  assign cfg_q     = {bias_q, auto_q, os_q, wire3_q, fcyc_q, 1'b0, filt_q};
  assign auto_en   = auto_q;
  assign filt50    = filt_q;
  assign os_fire   = cs_rise & os_q;
  assign clr_pulse = cfg_we & cfg_wdata[CB_CLEAR] & ~cfg_wdata[CB_ONESHOT] &
                     ~cfg_wdata[CB_FCYC_HI] & ~cfg_wdata[CB_FCYC_LO];
  assign hi_lim    = hi_q[RES_W-1:1];
  assign lo_lim    = lo_q[RES_W-1:1];

  // R4: combined one-shot / fault-cycle write changes neither field
  a_r4_combo_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[CB_ONESHOT] && (cfg_wdata[CB_FCYC_HI] || cfg_wdata[CB_FCYC_LO]))
    |=> (cfg_q[CB_ONESHOT] == $past(cfg_q[CB_ONESHOT])) &&
        (cfg_q[CB_FCYC_HI:CB_FCYC_LO] == $past(cfg_q[CB_FCYC_HI:CB_FCYC_LO])));

  // R3: transaction end consumes the one-shot request
  a_r3_oneshot_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !cfg_we) |=> !cfg_q[CB_ONESHOT]);

  // R13: sequencer completion returns the fault-cycle field to idle
  a_r13_fcyc_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fcyc_done && !cfg_we) |=> (cfg_q[CB_FCYC_HI:CB_FCYC_LO] == 2'b00));

endmodule

// File: rtl/rtd_conv_seq.sv
module rtd_conv_seq
  import rtd_ctrl_pkg::*;
#(
  parameter int T_SGL60  = 52,
  parameter int T_SGL50  = 63,
  parameter int T_CONT60 = 17,
  parameter int T_CONT50 = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic auto_en,
  input  logic filt50,
  input  logic os_fire,
  input  logic adc_valid,
  output logic adc_ready,
  output logic accept
);
  localparam int TMAX_S = (T_SGL60 > T_SGL50) ? T_SGL60 : T_SGL50;
  localparam int TMAX_C = (T_CONT60 > T_CONT50) ? T_CONT60 : T_CONT50;
  localparam int TMAX   = (TMAX_S > TMAX_C) ? TMAX_S : TMAX_C;
  localparam int CNT_W  = $clog2(TMAX + 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             launch_q;

  function automatic logic [CNT_W-1:0] load_val(input logic first, input logic f50);
    int t;
    if (first) t = f50 ? T_SGL50 : T_SGL60;
    else       t = f50 ? T_CONT50 : T_CONT60;
    return CNT_W'(t - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      launch_q <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (auto_en || launch_q) begin
            state_q  <= SQ_RUN;
            cnt_q    <= load_val(1'b1, filt50);
            launch_q <= 1'b0;
          end
        end
        SQ_RUN: begin
          if (tick) begin
            if (cnt_q == '0) state_q <= SQ_WAIT;
            else             cnt_q   <= cnt_q - 1'b1;
          end
        end
        SQ_WAIT: begin
          if (adc_valid) begin
            if (auto_en) begin
              state_q <= SQ_RUN;
              cnt_q   <= load_val(1'b0, filt50);
            end else if (launch_q) begin
              state_q  <= SQ_RUN;
              cnt_q    <= load_val(1'b1, filt50);
              launch_q <= 1'b0;
            end else begin
              state_q <= SQ_IDLE;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
      if (os_fire) launch_q <= 1'b1;
    end
  end

  assign adc_ready = (state_q == SQ_WAIT);
  assign accept    = adc_ready & adc_valid;

  // R12: readiness drops right after a handshake
  a_r12_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !adc_ready);

  // R2: readiness only ever follows a timer tick
  a_r2_ready_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_ready) |-> $past(tick));

  // R3: without a request or continuous mode the sequencer stays idle
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && !auto_en && !launch_q) |=> !adc_ready);

endmodule

// File: rtl/rtd_result_fault.sv
module rtd_result_fault
  import rtd_ctrl_pkg::*;
#(
  parameter int CODE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] adc_code,
  input  logic              ovuv,
  input  logic              clr,
  input  logic              rd,
  input  logic [CODE_W-1:0] hi_lim,
  input  logic [CODE_W-1:0] lo_lim,
  output logic [CODE_W-1:0] code_q,
  output logic [7:0]        status,
  output logic              drdy_n
);
  logic       store, hi_hit, lo_hit;
  logic [7:0] set_vec;
  logic [7:0] status_q;

  assign store   = accept & ~ovuv;
  assign hi_hit  = store & (adc_code >= hi_lim);
  assign lo_hit  = store & (adc_code <= lo_lim);
  assign set_vec = {hi_hit, lo_hit, 3'b000, ovuv, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (store) code_q <= adc_code;
  end

  for (genvar b = 0; b < 8; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= (status_q[b] & ~(clr & STATUS_CLR_MASK[b])) | set_vec[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     drdy_n <= 1'b1;
    else if (store) drdy_n <= 1'b0;
    else if (rd)    drdy_n <= 1'b1;
  end

  assign status = status_q;

  // R9: voltage flag latches one cycle after the input
  a_r9_volt_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ovuv |=> status[SB_VOLT]);

  // R9: codes offered during a voltage fault are discarded
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ovuv) |=> $stable(code_q));

  // R7: a stored code at or above the high limit raises the high flag
  a_r7_high_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (store && adc_code >= hi_lim) |=> status[SB_HIGH]);

  // R8: a stored code at or below the low limit raises the low flag
  a_r8_low_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (store && adc_code <= lo_lim) |=> status[SB_LOW]);

  // R10: a clear with nothing setting empties the status word
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovuv && !accept) |=> (status == 8'h00));

  // R11: store announces, read releases
  a_r11_store_flags: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> !drdy_n);
  a_r11_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !store) |=> drdy_n);

endmodule

// File: rtl/rtd_conv_ctrl.sv
module rtd_conv_ctrl
  import rtd_ctrl_pkg::*;
#(
  parameter int CODE_W   = 15,
  parameter int T_SGL60  = 52,
  parameter int T_SGL50  = 63,
  parameter int T_CONT60 = 17,
  parameter int T_CONT50 = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              thr_we,
  input  logic              thr_sel,
  input  logic [CODE_W:0]   thr_wdata,
  input  logic              cs_rise,
  input  logic              fcyc_done,
  input  logic              rd_result,
  input  logic              ovuv_fault,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  output logic              adc_ready,
  output logic [7:0]        cfg_q,
  output logic [CODE_W:0]   result,
  output logic [7:0]        fault_status,
  output logic              drdy_n
);
  logic              auto_en, filt50, os_fire, clr_pulse, accept;
  logic [CODE_W-1:0] hi_lim, lo_lim, code_q;

  rtd_cfg_reg #(.CODE_W(CODE_W)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .thr_we    (thr_we),
    .thr_sel   (thr_sel),
    .thr_wdata (thr_wdata),
    .cs_rise   (cs_rise),
    .fcyc_done (fcyc_done),
    .cfg_q     (cfg_q),
    .auto_en   (auto_en),
    .filt50    (filt50),
    .os_fire   (os_fire),
    .clr_pulse (clr_pulse),
    .hi_lim    (hi_lim),
    .lo_lim    (lo_lim)
  );

  rtd_conv_seq #(
    .T_SGL60  (T_SGL60),
    .T_SGL50  (T_SGL50),
    .T_CONT60 (T_CONT60),
    .T_CONT50 (T_CONT50)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .auto_en   (auto_en),
    .filt50    (filt50),
    .os_fire   (os_fire),
    .adc_valid (adc_valid),
    .adc_ready (adc_ready),
    .accept    (accept)
  );

  rtd_result_fault #(.CODE_W(CODE_W)) i_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .adc_code (adc_code),
    .ovuv     (ovuv_fault),
    .clr      (clr_pulse),
    .rd       (rd_result),
    .hi_lim   (hi_lim),
    .lo_lim   (lo_lim),
    .code_q   (code_q),
    .status   (fault_status),
    .drdy_n   (drdy_n)
  );

  assign result = {code_q, |fault_status};

  // R6: summary bit tracks the status word across a cycle boundary
  a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_status[SB_VOLT]) |-> result[0]);

endmodule

// File: tb/test_rtd_conv_ctrl.sv
module test_rtd_conv_ctrl;
  localparam int CW  = 15;
  localparam int S60 = 7, S50 = 9, C60 = 3, C50 = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic cfg_we = 0, thr_we = 0, thr_sel = 0, cs_rise = 0, fcyc_done = 0;
  logic rd_result = 0, ovuv_fault = 0, adc_valid = 0;
  logic [7:0] cfg_wdata = '0;
  logic [CW:0] thr_wdata = '0;
  logic [CW-1:0] adc_code = '0;
  logic adc_ready, drdy_n;
  logic [7:0] cfg_q, fault_status;
  logic [CW:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtd_conv_ctrl #(.CODE_W(CW), .T_SGL60(S60), .T_SGL50(S50),
                  .T_CONT60(C60), .T_CONT50(C50)) i_rtd_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_wdata(thr_wdata), .cs_rise(cs_rise),
    .fcyc_done(fcyc_done), .rd_result(rd_result), .ovuv_fault(ovuv_fault),
    .adc_valid(adc_valid), .adc_code(adc_code), .adc_ready(adc_ready),
    .cfg_q(cfg_q), .result(result), .fault_status(fault_status), .drdy_n(drdy_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d, input logic rd);
    cfg_we = 1; cfg_wdata = d; rd_result = rd;
    @(negedge clk);
    cfg_we = 0; rd_result = 0;
  endtask

  task automatic thr_write(input logic sel, input logic [CW:0] v);
    thr_we = 1; thr_sel = sel; thr_wdata = v;
    @(negedge clk);
    thr_we = 0;
  endtask

  task automatic pulse_cs();
    cs_rise = 1; @(negedge clk); cs_rise = 0;
  endtask

  task automatic pulse_rd();
    rd_result = 1; @(negedge clk); rd_result = 0;
  endtask

  task automatic pulse_fcyc();
    fcyc_done = 1; @(negedge clk); fcyc_done = 0;
  endtask

  task automatic count_ready(output int n);
    n = 0;
    while (!adc_ready) begin n++; @(negedge clk); end
  endtask

  task automatic accept_code(input logic [CW-1:0] c, input logic rd);
    adc_valid = 1; adc_code = c; rd_result = rd;
    @(negedge clk);
    adc_valid = 0; rd_result = 0;
  endtask

  function automatic logic [CW-1:0] sweep_code(input int i);
    if (i < 256) return CW'((i * 129) % 32768);
    case (i - 256)
      0: return 15'h0000; 1: return 15'h07FF; 2: return 15'h0800; 3: return 15'h0801;
      4: return 15'h2FFF; 5: return 15'h3000; 6: return 15'h3001; default: return 15'h7FFF;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 result", int'(result), 0);
    chk("R1 status", int'(fault_status), 0);
    chk("R1 cfg", int'(cfg_q), 0);
    chk("R1 drdy_n", int'(drdy_n), 1);
    chk("R1 ready", int'(adc_ready), 0);
    repeat (20) @(negedge clk);
    chk("R3 idle without request", int'(adc_ready), 0);

    // R3 one-shot armed, fired by transaction end
    cfg_write(8'h20, 0);
    chk("R3 oneshot armed", int'(cfg_q[5]), 1);
    repeat (6) @(negedge clk);
    chk("R3 waits for cs", int'(adc_ready), 0);
    pulse_cs();
    chk("R3 oneshot self-clear", int'(cfg_q[5]), 0);
    count_ready(n);
    chk("R3 single 60 duration", n, S60 + 1);
    accept_code(15'h1234, 0);
    chk("R6 result format", int'(result), 16'h2468);
    chk("R7 R8 no flags", int'(fault_status), 0);
    chk("R11 drdy low on store", int'(drdy_n), 0);
    repeat (4) @(negedge clk);
    chk("R3 single conversion only", int'(adc_ready), 0);
    pulse_rd();
    chk("R11 drdy high after read", int'(drdy_n), 1);

    // R5 filter selection and sampling
    cfg_write(8'h21, 0);
    pulse_cs();
    count_ready(n);
    chk("R5 single 50 duration", n, S50 + 1);
    accept_code(15'h0100, 0);
    chk("R6 result 0100", int'(result), 16'h0200);
    cfg_write(8'h20, 0);
    pulse_cs();
    cfg_wdata = 8'h01;
    n = 0;
    while (!adc_ready) begin cfg_we = (n == 2); n++; @(negedge clk); end
    cfg_we = 0;
    chk("R5 filter sampled at start", n, S60 + 1);
    accept_code(15'h0200, 1);
    chk("R11 store beats read", int'(drdy_n), 0);

    // R2 continuous mode
    cfg_write(8'h40, 0);
    count_ready(n);
    chk("R2 first continuous uses single time", n, S60 + 1);
    accept_code(15'h7FFF, 0);
    chk("R7 reset high limit trips at 7FFF", int'(fault_status[7]), 1);
    chk("R8 low not set", int'(fault_status[6]), 0);
    chk("R6 summary bit", int'(result[0]), 1);
    count_ready(n);
    chk("R2 chained duration", n, C60);
    accept_code(15'h0000, 0);
    chk("R8 reset low limit trips at 0", int'(fault_status[6]), 1);
    chk("R7 high stays latched", int'(fault_status[7]), 1);
    count_ready(n);
    chk("R2 chained duration again", n, C60);
    repeat (5) @(negedge clk);
    chk("R12 ready held", int'(adc_ready), 1);
    chk("R12 result held", int'(result[15:1]), 0);
    accept_code(15'h0005, 0);
    chk("R12 ready drops after accept", int'(adc_ready), 0);
    chk("R6 result with fault", int'(result), 16'h000B);
    cfg_write(8'h42, 1);
    chk("R10 clear", int'(fault_status), 0);
    chk("R10 clear bit reads 0", int'(cfg_q[1]), 0);
    chk("R6 summary cleared", int'(result), 16'h000A);

    // R6 R7 R8 R10 R11 sweep around programmed limits
    thr_write(1, 16'h6000);
    thr_write(0, 16'h1000);
    for (int i = 0; i < 264; i++) begin
      logic [CW-1:0] c;
      int e7, e6;
      c = sweep_code(i);
      e7 = (c >= 15'h3000) ? 1 : 0;
      e6 = (c <= 15'h0800) ? 1 : 0;
      count_ready(n);
      accept_code(c, 0);
      chk("R6 sweep code", int'(result[15:1]), int'(c));
      chk("R7 sweep high", int'(fault_status[7]), e7);
      chk("R8 sweep low", int'(fault_status[6]), e6);
      chk("R6 sweep summary", int'(result[0]), e7 | e6);
      chk("R11 sweep drdy", int'(drdy_n), 0);
      cfg_write(8'h42, 1);
      chk("R10 sweep clear", int'(fault_status), 0);
      chk("R11 sweep read", int'(drdy_n), 1);
    end

    // R10 clear refused, R13 fault-cycle field
    count_ready(n);
    accept_code(15'h3000, 0);
    cfg_write(8'h46, 0);
    chk("R10 no clear with bit2", int'(fault_status[7]), 1);
    chk("R13 fcyc stored", int'(cfg_q[3:2]), 1);
    pulse_fcyc();
    chk("R13 fcyc done", int'(cfg_q[3:2]), 0);
    cfg_write(8'h42, 0);
    chk("R10 clear after", int'(fault_status), 0);
    pulse_rd();

    // R9 voltage fault freeze
    ovuv_fault = 1;
    @(negedge clk);
    chk("R9 volt flag", int'(fault_status[2]), 1);
    chk("R6 summary on volt", int'(result[0]), 1);
    count_ready(n);
    accept_code(15'h0123, 0);
    chk("R9 result frozen", int'(result[15:1]), 16'h3000);
    chk("R9 drdy unchanged", int'(drdy_n), 1);
    cfg_write(8'h42, 0);
    chk("R10 volt re-sets", int'(fault_status[2]), 1);
    ovuv_fault = 0;
    cfg_write(8'h42, 0);
    chk("R10 clear after volt", int'(fault_status), 0);
    count_ready(n);
    accept_code(15'h0456, 0);
    chk("R9 updates resume", int'(result[15:1]), 16'h0456);

    // R4 combined command ignored
    cfg_write(8'h00, 0);
    count_ready(n);
    accept_code(15'h0010, 1);
    repeat (3) @(negedge clk);
    chk("R2 stops after leaving continuous", int'(adc_ready), 0);
    cfg_write(8'h28, 0);
    chk("R4 oneshot ignored", int'(cfg_q[5]), 0);
    chk("R4 fcyc ignored", int'(cfg_q[3:2]), 0);
    pulse_cs();
    repeat (30) @(negedge clk);
    chk("R4 no conversion", int'(adc_ready), 0);

    finish_run();
  end
endmodule